// File: doc/BRIEF.md
# Serial S-record Program Loader

This block loads a program image into on-chip program memory over a single UART receive line. A host streams an S-record text file at 115200 baud, 8 data bits, no parity and one stop bit, with no flow control of any kind. The block decodes each character, parses the record structure and checks every record's checksum. It then writes the record's data into a word-wide memory port, using byte enables. No debug adapter is needed.

While a load is in progress, `hold_o` keeps the processor in reset. A termination record releases it. A record with a bad checksum is thrown away and leaves a sticky error flag. Line breaks and stray characters between records have no effect.

Internally, a 16x oversampling receiver (`U_IDLE` to `U_START` on a low sample; `U_START` to `U_DATA` if the line is still low at mid start bit, otherwise back to `U_IDLE`; `U_DATA` to `U_STOP` after eight bits; `U_STOP` to `U_IDLE` on a high stop bit, or to `U_BREAK` on a low one; `U_BREAK` to `U_IDLE` once the line is high) passes characters to a record parser. The parser moves through `P_HUNT` (to `P_TYPE` on 'S'), `P_TYPE` (to `P_COUNT` on a known type digit, else back to `P_HUNT`), `P_COUNT`, `P_ADDR`, `P_DATA` and `P_SUM`. From `P_SUM` it goes to `P_EMIT` when the record is a good data record with a payload, and to `P_HUNT` otherwise. Any non-hex character in a field state returns the parser to `P_HUNT`. `P_EMIT` returns to `P_HUNT` after the last buffered byte. During `P_EMIT` the data bytes go one per cycle to a word packer that drives the memory port.

Top module: `srec_loader`

## Requirements
- R1: Reception is 8N1, LSB first, oversampled 16 times per bit, where one sixteenth of a bit lasts CLKS_PER_TICK clocks. A start bit counts only if the line is still low at mid start bit, so a low pulse shorter than half a bit produces no character.
- R2: A frame whose stop bit samples low is discarded, and the receiver waits for the line to go high before it looks for a new start bit.
- R3: A record is 'S', a type digit, a two-hex-digit count, then the address, data and checksum bytes, each byte written as two hex digits in upper or lower case. The address is 2 bytes for types 0, 1, 5 and 9, 3 bytes for types 2, 6 and 8, and 4 bytes for types 3 and 7. The address is big-endian and the count covers address, data and checksum.
- R4: The checksum byte must equal the ones' complement of the low 8 bits of the sum of the count, address and data bytes. On a mismatch `err_o` is set and none of that record's data is written.
- R5: A data byte at byte address A goes to word address A[15:2], in bits 8*A[1:0]+7 down to 8*A[1:0] of `mem_wdata_o`, with `mem_be_o` bit A[1:0] set. Bytes within a word are little-endian.
- R6: A write is issued when lane 3 is filled or when the record's last data byte is placed. Lanes not written carry zero data and a cleared enable, and there is exactly one write per touched word.
- R7: `hold_o` rises on an 'S' seen between records. It falls only after a type 7, 8 or 9 record with a valid checksum, and the parser then returns to hunting.
- R8: Characters between records (CR, LF, others) are ignored. A non-hex character inside a record abandons it with no writes. Records of types 0, 5 and 6 are checked but write nothing.
- R9: After reset `mem_we_o`, `hold_o` and `err_o` are low. `err_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | UART receive line, idle high |
| mem_we_o | output | 1 | One-cycle program memory write strobe |
| mem_addr_o | output | MEM_AW | Word address of the write |
| mem_wdata_o | output | 32 | Write data, little-endian byte lanes |
| mem_be_o | output | 4 | Byte enables, bit n for bits 8n+7:8n |
| hold_o | output | 1 | Holds the processor in reset while loading |
| err_o | output | 1 | Sticky checksum error flag |

## Verification
The assertions check on every cycle that:
- received characters are single-cycle pulses backed by a high stop sample;
- every write has a non-empty byte enable and zero data in disabled lanes;
- writes happen only while the processor is held;
- `hold_o` falls only out of the checksum state;
- `err_o` never clears.

Only the bench scenarios can show the rest: correct lane placement for unaligned and 3- and 4-byte addresses, that bad-checksum, aborted and header records leave memory untouched, and that glitches and broken frames inside a record leave its contents intact.

// File: rtl/srec_pkg.sv
package srec_pkg;

    typedef enum logic [2:0] {
        P_HUNT, P_TYPE, P_COUNT, P_ADDR, P_DATA, P_SUM, P_EMIT
    } pstate_t;

    typedef enum logic [1:0] {K_DATA, K_TERM, K_INFO, K_BAD} rkind_t;

    // {valid, nibble}
    function automatic logic [4:0] hex_val(input logic [7:0] c);
        if (c >= 8'h30 && c <= 8'h39) return {1'b1, 4'(c - 8'h30)};
        if (c >= 8'h41 && c <= 8'h46) return {1'b1, 4'(c - 8'h37)};
        if (c >= 8'h61 && c <= 8'h66) return {1'b1, 4'(c - 8'h57)};
        return 5'd0;
    endfunction

    function automatic rkind_t rec_kind(input logic [3:0] t);
        unique case (t)
            4'd1, 4'd2, 4'd3: return K_DATA;
            4'd7, 4'd8, 4'd9: return K_TERM;
            4'd0, 4'd5, 4'd6: return K_INFO;
            default:          return K_BAD;
        endcase
    endfunction

    function automatic logic [2:0] addr_bytes(input logic [3:0] t);
        unique case (t)
            4'd0, 4'd1, 4'd5, 4'd9: return 3'd2;
            4'd2, 4'd6, 4'd8:       return 3'd3;
            4'd3, 4'd7:             return 3'd4;
            default:                return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/srec_uart_rx.sv
module srec_uart_rx #(
    parameter int CLKS_PER_TICK = 27,
    parameter int OSR           = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    output logic       byte_vld_o,
    output logic [7:0] byte_o
);
    localparam int DIVW = $clog2(CLKS_PER_TICK) + 1;
    localparam int OSW  = $clog2(OSR);
    localparam int HALF = OSR / 2;

    typedef enum logic [2:0] {U_IDLE, U_START, U_DATA, U_STOP, U_BREAK} ustate_t;

    ustate_t          state_q, nxt;
    logic             rx_s1, rx_s2;
    logic [DIVW-1:0]  div_q;
    logic             tick;
    logic [OSW-1:0]   os_q;
    logic [2:0]       bit_q;
    logic [7:0]       shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_s1 <= 1'b1;
            rx_s2 <= 1'b1;
            div_q <= '0;
        end else begin
            rx_s1 <= rx_i;
            rx_s2 <= rx_s1;
            div_q <= tick ? '0 : div_q + DIVW'(1);
        end
    end

    assign tick = (div_q == DIVW'(CLKS_PER_TICK - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= U_IDLE;
        else        state_q <= nxt;
    end

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            U_IDLE:  if (tick && !rx_s2) nxt = U_START;
            U_START: if (tick && os_q == OSW'(HALF - 1)) nxt = rx_s2 ? U_IDLE : U_DATA;
            U_DATA:  if (tick && os_q == OSW'(OSR - 1) && bit_q == 3'd7) nxt = U_STOP;
            U_STOP:  if (tick && os_q == OSW'(OSR - 1)) nxt = rx_s2 ? U_IDLE : U_BREAK;
            U_BREAK: if (rx_s2) nxt = U_IDLE;
            default: nxt = U_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q       <= '0;
            bit_q      <= '0;
            shift_q    <= '0;
            byte_vld_o <= 1'b0;
            byte_o     <= '0;
        end else begin
            byte_vld_o <= 1'b0;
            if (tick) begin
                unique case (state_q)
                    U_IDLE: begin
                        os_q  <= '0;
                        bit_q <= '0;
                    end
                    U_START: os_q <= (os_q == OSW'(HALF - 1)) ? '0 : os_q + OSW'(1);
                    U_DATA: begin
                        os_q <= os_q + OSW'(1);
                        if (os_q == OSW'(OSR - 1)) begin
                            shift_q <= {rx_s2, shift_q[7:1]};
                            bit_q   <= bit_q + 3'd1;
                        end
                    end
                    U_STOP: begin
                        os_q <= os_q + OSW'(1);
                        if (os_q == OSW'(OSR - 1) && rx_s2) begin
                            byte_vld_o <= 1'b1;
                            byte_o     <= shift_q;
                        end
                    end
                    default: os_q <= '0;
                endcase
            end
        end
    end

    // R1
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |=> !byte_vld_o);

    // R2
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> $past(rx_s2));

endmodule

// File: rtl/srec_parser.sv
module srec_parser
    import srec_pkg::*;
#(
    parameter int BA_W      = 16,
    parameter int MAX_BYTES = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ch_vld_i,
    input  logic [7:0]      ch_i,
    output logic            emit_vld_o,
    output logic [7:0]      emit_byte_o,
    output logic [BA_W-1:0] emit_addr_o,
    output logic            emit_last_o,
    output logic            hold_o,
    output logic            err_o
);
    localparam int IDX_W = $clog2(MAX_BYTES);

    pstate_t          state_q, nxt;
    rkind_t           kind_q;
    logic [2:0]       alen_q, aleft_q;
    logic [7:0]       remain_q, sum_q;
    logic [BA_W-1:0]  addr_q;
    logic [IDX_W-1:0] nbytes_q, idx_q;
    logic             hi_q;
    logic [3:0]       nib_q;
    logic [7:0]       dbuf [MAX_BYTES];

    logic [4:0] hv;
    logic       is_hex, pair_done, is_digit, sum_ok;
    logic [7:0] byte_w;
    logic [3:0] digit;

    assign hv        = hex_val(ch_i);
    assign is_hex    = hv[4];
    assign pair_done = ch_vld_i && is_hex && hi_q;
    assign byte_w    = {nib_q, hv[3:0]};
    assign is_digit  = (ch_i[7:4] == 4'h3) && (ch_i[3:0] <= 4'd9);
    assign digit     = ch_i[3:0];
    assign sum_ok    = (byte_w == ~sum_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= P_HUNT;
        else        state_q <= nxt;
    end

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            P_HUNT: if (ch_vld_i && ch_i == 8'h53) nxt = P_TYPE;
            P_TYPE: if (ch_vld_i)
                        nxt = (is_digit && rec_kind(digit) != K_BAD) ? P_COUNT : P_HUNT;
            P_COUNT, P_ADDR, P_DATA, P_SUM: begin
                if (ch_vld_i && !is_hex) nxt = P_HUNT;
                else if (pair_done) begin
                    if (state_q == P_COUNT)
                        nxt = (byte_w < ({5'd0, alen_q} + 8'd1)) ? P_HUNT : P_ADDR;
                    else if (state_q == P_ADDR) begin
                        if (aleft_q == 3'd1) nxt = (remain_q == 8'd2) ? P_SUM : P_DATA;
                    end else if (state_q == P_DATA) begin
                        if (remain_q == 8'd2) nxt = P_SUM;
                    end else
                        nxt = (sum_ok && kind_q == K_DATA && nbytes_q != '0) ? P_EMIT : P_HUNT;
                end
            end
            P_EMIT: if (emit_last_o) nxt = P_HUNT;
            default: nxt = P_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q   <= K_BAD;
            alen_q   <= '0;
            aleft_q  <= '0;
            remain_q <= '0;
            sum_q    <= '0;
            addr_q   <= '0;
            nbytes_q <= '0;
            idx_q    <= '0;
            hi_q     <= 1'b0;
            nib_q    <= '0;
            hold_o   <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            unique case (state_q)
                P_HUNT: begin
                    hi_q <= 1'b0;
                    if (ch_vld_i && ch_i == 8'h53) hold_o <= 1'b1;
                end
                P_TYPE: if (ch_vld_i) begin
                    kind_q <= rec_kind(digit);
                    alen_q <= addr_bytes(digit);
                    hi_q   <= 1'b0;
                end
                P_COUNT, P_ADDR, P_DATA, P_SUM: if (ch_vld_i) begin
                    if (!is_hex) hi_q <= 1'b0;
                    else if (!hi_q) begin
                        nib_q <= hv[3:0];
                        hi_q  <= 1'b1;
                    end else begin
                        hi_q <= 1'b0;
                        if (state_q == P_COUNT) begin
                            remain_q <= byte_w;
                            sum_q    <= byte_w;
                            aleft_q  <= alen_q;
                            addr_q   <= '0;
                            nbytes_q <= '0;
                        end else if (state_q == P_ADDR) begin
                            addr_q   <= {addr_q[BA_W-9:0], byte_w};
                            sum_q    <= sum_q + byte_w;
                            remain_q <= remain_q - 8'd1;
                            aleft_q  <= aleft_q - 3'd1;
                        end else if (state_q == P_DATA) begin
                            nbytes_q <= nbytes_q + IDX_W'(1);
                            sum_q    <= sum_q + byte_w;
                            remain_q <= remain_q - 8'd1;
                        end else begin
                            idx_q <= '0;
                            if (!sum_ok)                err_o  <= 1'b1;
                            else if (kind_q == K_TERM)  hold_o <= 1'b0;
                        end
                    end
                end
                P_EMIT: idx_q <= idx_q + IDX_W'(1);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (state_q == P_DATA && pair_done) dbuf[nbytes_q] <= byte_w;
    end

    assign emit_vld_o  = (state_q == P_EMIT);
    assign emit_byte_o = dbuf[idx_q];
    assign emit_addr_o = addr_q + BA_W'(idx_q);
    assign emit_last_o = (idx_q == nbytes_q - IDX_W'(1));

    // R7
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_o) |-> $past(state_q) == P_SUM);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R6
    emit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_vld_o && emit_last_o) |=> state_q == P_HUNT);

endmodule

// File: rtl/srec_packer.sv
module srec_packer #(
    parameter int MEM_AW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bv_i,
    input  logic [7:0]        byte_i,
    input  logic [MEM_AW+1:0] baddr_i,
    input  logic              last_i,
    output logic              we_o,
    output logic [MEM_AW-1:0] waddr_o,
    output logic [31:0]       wdata_o,
    output logic [3:0]        wbe_o
);
    logic [31:0] acc_d_q, merged_d, be_mask;
    logic [3:0]  acc_b_q, merged_b;
    logic [1:0]  lane;
    logic        flush;

    assign lane     = baddr_i[1:0];
    assign merged_d = acc_d_q | ({24'd0, byte_i} << (8 * lane));
    assign merged_b = acc_b_q | (4'b0001 << lane);
    assign flush    = (lane == 2'd3) || last_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_d_q <= '0;
            acc_b_q <= '0;
            we_o    <= 1'b0;
            waddr_o <= '0;
            wdata_o <= '0;
            wbe_o   <= '0;
        end else begin
            we_o <= 1'b0;
            if (bv_i) begin
                if (flush) begin
                    we_o    <= 1'b1;
                    waddr_o <= baddr_i[MEM_AW+1:2];
                    wdata_o <= merged_d;
                    wbe_o   <= merged_b;
                    acc_d_q <= '0;
                    acc_b_q <= '0;
                end else begin
                    acc_d_q <= merged_d;
                    acc_b_q <= merged_b;
                end
            end
        end
    end

    always_comb begin
        for (int k = 0; k < 4; k++) be_mask[8*k +: 8] = {8{wbe_o[k]}};
    end

    // R5
    lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> ((wdata_o & ~be_mask) == 32'd0));

    // R6
    be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> wbe_o != 4'd0);

endmodule

// File: rtl/srec_loader.sv
module srec_loader #(
    parameter int CLKS_PER_TICK = 27,
    parameter int MEM_AW        = 14,
    parameter int MAX_BYTES     = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    output logic              mem_we_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    output logic [3:0]        mem_be_o,
    output logic              hold_o,
    output logic              err_o
);
    localparam int BA_W = MEM_AW + 2;

    logic            ch_vld;
    logic [7:0]      ch;
    logic            em_vld, em_last;
    logic [7:0]      em_byte;
    logic [BA_W-1:0] em_addr;

    srec_uart_rx #(.CLKS_PER_TICK(CLKS_PER_TICK), .OSR(16)) rx_u (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i),
        .byte_vld_o(ch_vld), .byte_o(ch)
    );

    srec_parser #(.BA_W(BA_W), .MAX_BYTES(MAX_BYTES)) parse_u (
        .clk(clk), .rst_n(rst_n), .ch_vld_i(ch_vld), .ch_i(ch),
        .emit_vld_o(em_vld), .emit_byte_o(em_byte), .emit_addr_o(em_addr),
        .emit_last_o(em_last), .hold_o(hold_o), .err_o(err_o)
    );

    srec_packer #(.MEM_AW(MEM_AW)) pack_u (
        .clk(clk), .rst_n(rst_n), .bv_i(em_vld), .byte_i(em_byte),
        .baddr_i(em_addr), .last_i(em_last),
        .we_o(mem_we_o), .waddr_o(mem_addr_o), .wdata_o(mem_wdata_o), .wbe_o(mem_be_o)
    );

    // R7
    we_under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> hold_o);

endmodule

// File: tb/srec_loader_tb.sv
module srec_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CPT        = 2;
    localparam int BIT_CLKS   = 16 * CPT;
    localparam int AW         = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx = 1'b1;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [3:0]    mem_be;
    logic          hold, err;

    int  nchk = 0, nfail = 0;
    bit  exp_hold = 0, exp_err = 0;
    int          exp_a[$];
    logic [31:0] exp_d[$];
    logic [3:0]  exp_b[$];
    logic [7:0]  pl[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    srec_loader #(.CLKS_PER_TICK(CPT), .MEM_AW(AW), .MAX_BYTES(256)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_i(rx),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_be_o(mem_be), .hold_o(hold), .err_o(err)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // per-clock comparison of the write port against the model (R5, R6)
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_a.size() == 0) chk("R6", "unexpected write addr", mem_addr, 0);
            else begin
                chk("R5", "write addr", mem_addr, exp_a.pop_front());
                chk("R5", "write data", mem_wdata, exp_d.pop_front());
                chk("R6", "write be", mem_be, exp_b.pop_front());
            end
        end
    end

    task automatic send_frame(input logic [7:0] b, input bit good_stop);
        rx = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        rx = good_stop;
        repeat (BIT_CLKS) @(negedge clk);
        if (!good_stop) begin
            rx = 1'b1;
            repeat (BIT_CLKS) @(negedge clk);
        end
    endtask

    function automatic logic [7:0] hexch(input int n, input bit lc);
        if (n < 10) return 8'(8'h30 + n);
        return 8'((lc ? 8'h61 : 8'h41) + n - 10);
    endfunction

    task automatic send_hex(input logic [7:0] b, input bit lc);
        send_frame(hexch(b[7:4], lc), 1'b1);
        send_frame(hexch(b[3:0], lc), 1'b1);
    endtask

    // mode: 0 clean, 1 broken-stop frame after address, 2 abort with 'x', 3 bad checksum
    task automatic send_record(input int typ, input int addr, input int alen,
                               input int mode, input bit lc);
        int          count;
        logic [7:0]  sum, ck;
        logic [31:0] wd;
        logic [3:0]  wb;
        int          a, ln;
        count = alen + pl.size() + 1;
        sum   = 8'(count);
        for (int k = 0; k < alen; k++) sum = sum + 8'(addr >> (8*k));
        foreach (pl[i]) sum = sum + pl[i];
        ck = ~sum;
        if (mode == 3) ck = ck ^ 8'h01;
        exp_hold = 1;
        if (mode == 3) exp_err = 1;
        else if (mode != 2) begin
            if (typ >= 7 && typ <= 9) exp_hold = 0;
            if (typ >= 1 && typ <= 3) begin
                wd = 0; wb = 0;
                foreach (pl[i]) begin
                    a  = addr + i;
                    ln = a & 3;
                    wd = wd | (32'(pl[i]) << (8*ln));
                    wb = wb | 4'(1 << ln);
                    if (ln == 3 || i == pl.size() - 1) begin
                        exp_a.push_back((a >> 2) & ((1 << AW) - 1));
                        exp_d.push_back(wd);
                        exp_b.push_back(wb);
                        wd = 0; wb = 0;
                    end
                end
            end
        end
        send_frame(8'h53, 1'b1);
        send_frame(8'(8'h30 + typ), 1'b1);
        send_hex(8'(count), lc);
        for (int k = alen - 1; k >= 0; k--) send_hex(8'(addr >> (8*k)), lc);
        if (mode == 1) send_frame(8'h46, 1'b0);
        foreach (pl[i]) begin
            if (mode == 2 && i == 1) send_frame(8'h78, 1'b1);
            send_hex(pl[i], lc);
        end
        send_hex(ck, lc);
        send_frame(8'h0D, 1'b1);
        send_frame(8'h0A, 1'b1);
        chk("R7", "hold after record", hold, exp_hold);
        chk("R4", "err after record", err, exp_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9", "we at reset", mem_we, 0);
        chk("R9", "hold at reset", hold, 0);
        chk("R9", "err at reset", err, 0);

        // R3 R5 R6: aligned 16-bit address record
        pl = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
        send_record(1, 32'h0100, 2, 0, 0);

        // R2: broken frame inside an unaligned 24-bit address record
        pl = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5};
        send_record(2, 32'h012345, 3, 1, 0);

        // R3: 32-bit address, lower-case hex
        pl = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h01, 8'h02};
        send_record(3, 32'hDEADBEE8, 4, 0, 1);

        // R8: junk between records; R1: short start glitch
        send_frame(8'h0D, 1'b1);
        send_frame(8'h0A, 1'b1);
        send_frame(8'h23, 1'b1);
        send_frame(8'h20, 1'b1);
        rx = 1'b0;
        repeat (4) @(negedge clk);
        rx = 1'b1;
        repeat (4 * BIT_CLKS) @(negedge clk);
        chk("R1", "hold after glitch", hold, 1);
        chk("R8", "err after junk", err, 0);

        // R8: header record writes nothing
        pl = '{8'h48, 8'h44, 8'h52};
        send_record(0, 0, 2, 0, 0);

        // R4: bad checksum, record dropped, err set
        pl = '{8'h01, 8'h02, 8'h03, 8'h04};
        send_record(1, 32'h0300, 2, 3, 0);

        // R8: abandoned record
        pl = '{8'h09, 8'h08, 8'h07, 8'h06};
        send_record(1, 32'h0200, 2, 2, 0);

        // R6: single byte into lane 3
        pl = '{8'h5A};
        send_record(1, 32'h0203, 2, 0, 0);

        // R7: termination releases hold; R9 err stays
        pl = {};
        send_record(9, 0, 2, 0, 0);
        chk("R9", "err still set", err, 1);

        // R7: next load raises hold again
        pl = '{8'hC0, 8'hFF, 8'hEE, 8'h01};
        send_record(1, 32'h0004, 2, 0, 0);

        repeat (2000) @(negedge clk);
        chk("R6", "pending expected writes", exp_a.size(), 0);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule